// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block takes configuration words from a three-wire serial link (a clock, a data line and a load strobe) and stores them in a bank of eight 8-bit parameter registers. Each frame is eleven bits long: a 3-bit register address, then an 8-bit value. The bank drives every stored byte in parallel to the rest of the sensor logic, so registers can be rewritten at any time, including while image data is being read out.

Capture and commit happen on opposite clock edges. Bits are sampled on rising edges. The addressed register takes its new value on the falling edge after the last bit is sampled. A mode bit in the edge/gain register forces fixed values onto the two filter-kernel outputs, P and M. While that bit is set, writes to those two registers are refused.

The block has two active-low synchronous resets. The system reset clears the framing logic. The register reset clears the bank.

Top module: `sercfg_loader`

## Requirements
- R1: A frame is 11 bits sampled on rising clock edges while `ser_load` is high, sent address first and most significant bit first. The layout is A2 A1 A0 then D7 down to D0. Address k (0 to 7) writes the k-th register output in the port list order: calib, edge_gain, expo_hi, expo_lo, kern_p, kern_m, kern_x, misc.
- R2: The addressed register changes on the falling edge that follows the rising edge sampling the 11th bit. At that rising edge and up to the falling edge, the output still shows the old value.
- R3: Each accepted write raises `cfg_commit_o` for exactly one clock cycle, from that falling edge to the next one. During that cycle `cfg_commit_addr_o` shows the written address. No other event raises `cfg_commit_o`.
- R4: If `ser_load` falls before 11 bits have been sampled, the partial frame is discarded. No register changes and no commit pulse occurs.
- R5: Once 11 bits are taken, further bits are ignored while `ser_load` stays high. A new frame starts only after `ser_load` has been low for at least one rising edge.
- R6: While `regs_rst_n` is low at a falling edge, all eight registers clear to 0x00 and no write is accepted.
- R7: While `rst_n` is low at a rising edge, any partially received frame is dropped. Bits that follow it start a fresh frame count.
- R8: Bit 7 of the register at address 1 is the kernel-override bit. While it is 1, `reg_kern_p_o` reads 0x02 and `reg_kern_m_o` reads 0x05.
- R9: While the override bit is 1, frames addressed to 4 or 5 are ignored: no stored change and no commit pulse. After the bit is cleared, the value stored before the override is shown again.
- R10: While the override bit is 1, frames addressed to any register other than 4 and 5 are still written and produce a commit pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial and system clock |
| rst_n | input | 1 | Active-low synchronous reset of the framing logic |
| regs_rst_n | input | 1 | Active-low synchronous reset of the register bank |
| ser_load | input | 1 | Frame strobe; bits are taken while high |
| ser_din | input | 1 | Serial data, address then data, MSB first |
| reg_calib_o | output | 8 | Register 0: zero calibration and offset |
| reg_edge_gain_o | output | 8 | Register 1: override bit, edge mode, gain |
| reg_expo_hi_o | output | 8 | Register 2: coarse exposure byte |
| reg_expo_lo_o | output | 8 | Register 3: fine exposure byte |
| reg_kern_p_o | output | 8 | Register 4: kernel P, forced while override set |
| reg_kern_m_o | output | 8 | Register 5: kernel M, forced while override set |
| reg_kern_x_o | output | 8 | Register 6: kernel X |
| reg_misc_o | output | 8 | Register 7: edge ratio, invert, bias select |
| cfg_commit_o | output | 1 | One-cycle pulse for each accepted write |
| cfg_commit_addr_o | output | 3 | Address of the latest accepted write |

## Verification
The hardest situation to reach from the ports is the half cycle between capture and commit. There, the 11th bit has been sampled but the register has not yet changed. The stimulus reaches it by driving the last bit by hand and sampling once just after that rising edge and once just after the following falling edge. A second hard case is a blocked write to a kernel register while the override is set. It must leave no trace at all. The bench sets the override, sends the refused frames, and then clears the override so that the stored value comes back out of the P and M ports.

// File: rtl/sercfg_pkg.sv
// Package: shared sizes, fixed addresses and forced kernel values of the
// serial configuration loader. Assumes eight 8-bit registers by default.
package sercfg_pkg;
    localparam int REG_COUNT_DEF  = 8;
    localparam int DATA_W_DEF     = 8;
    localparam int ADDR_MODE      = 1;   // register holding the override bit
    localparam int MODE_N_BIT     = 7;   // override bit position in it
    localparam int ADDR_KERN_P    = 4;
    localparam int ADDR_KERN_M    = 5;
    localparam logic [7:0] KERN_P_FORCED = 8'h02;
    localparam logic [7:0] KERN_M_FORCED = 8'h05;
endpackage

// File: rtl/sercfg_shifter.sv
// Module: sercfg_shifter
// Samples serial bits on rising edges while the load strobe is high and
// flags a complete frame for one cycle. Assumes the strobe and data are
// synchronous to clk. A frame shorter than FRAME_LEN is dropped when the
// strobe falls; extra bits after a full frame are ignored.
module sercfg_shifter #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_load,
    input  logic              ser_din,
    output logic              frm_vld,
    output logic [ADDR_W-1:0] frm_addr,
    output logic [DATA_W-1:0] frm_data
);
    localparam int FRAME_LEN = ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_LEN);

    logic [FRAME_LEN-1:0] shreg;
    logic [CNT_W-1:0]     bit_cnt;

    // Shift bits in, count them, and raise the frame flag on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
            frm_vld <= 1'b0;
        end else begin
            frm_vld <= 1'b0;
            if (!ser_load) begin
                bit_cnt <= '0;
            end else if (bit_cnt < FULL_CNT) begin
                shreg   <= {shreg[FRAME_LEN-2:0], ser_din};
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_IDX)
                    frm_vld <= 1'b1;
            end
        end
    end

    // Split the held frame into address and data fields.
    always_comb begin
        frm_addr = shreg[FRAME_LEN-1 -: ADDR_W];
        frm_data = shreg[DATA_W-1:0];
    end
endmodule

// File: rtl/sercfg_bank.sv
// Module: sercfg_bank
// Register bank updated on the falling clock edge after a frame is flagged.
// Assumes frm_* are stable from the flagging rising edge onward. Writes to
// the kernel P/M addresses are refused while the override bit is stored.
module sercfg_bank #(
    parameter int REG_COUNT = 8,
    parameter int DATA_W    = 8
) (
    input  logic                          clk,
    input  logic                          regs_rst_n,
    input  logic                          frm_vld,
    input  logic [$clog2(REG_COUNT)-1:0]  frm_addr,
    input  logic [DATA_W-1:0]             frm_data,
    output logic [REG_COUNT*DATA_W-1:0]   bank_flat,
    output logic                          commit_o,
    output logic [$clog2(REG_COUNT)-1:0]  commit_addr_o
);
    import sercfg_pkg::*;
    localparam int ADDR_W = $clog2(REG_COUNT);

    logic override_n;
    logic blocked;
    logic accept;

    // Decide whether the pending frame may be written.
    always_comb begin
        override_n = bank_flat[ADDR_MODE*DATA_W + MODE_N_BIT];
        blocked    = override_n &&
                     ((frm_addr == ADDR_W'(ADDR_KERN_P)) ||
                      (frm_addr == ADDR_W'(ADDR_KERN_M)));
        accept     = frm_vld && !blocked;
    end

    genvar gi;
    generate
        for (gi = 0; gi < REG_COUNT; gi++) begin : g_reg
            // Store one register on the falling edge when addressed.
            always_ff @(negedge clk) begin
                if (!regs_rst_n)
                    bank_flat[gi*DATA_W +: DATA_W] <= '0;
                else if (accept && (frm_addr == ADDR_W'(gi)))
                    bank_flat[gi*DATA_W +: DATA_W] <= frm_data;
            end
        end
    endgenerate

    // Produce the one-cycle commit pulse and its address.
    always_ff @(negedge clk) begin
        if (!regs_rst_n) begin
            commit_o      <= 1'b0;
            commit_addr_o <= '0;
        end else begin
            commit_o <= accept;
            if (accept)
                commit_addr_o <= frm_addr;
        end
    end
endmodule

// File: rtl/sercfg_override.sv
// Module: sercfg_override
// Output stage: replaces the kernel P and M bytes with fixed values while
// the override bit is stored. Assumes the bank is packed by address.
module sercfg_override #(
    parameter int REG_COUNT = 8,
    parameter int DATA_W    = 8
) (
    input  logic [REG_COUNT*DATA_W-1:0] bank_flat,
    output logic [REG_COUNT*DATA_W-1:0] view_flat
);
    import sercfg_pkg::*;

    // Substitute forced kernel values when the override bit is set.
    always_comb begin
        view_flat = bank_flat;
        if (bank_flat[ADDR_MODE*DATA_W + MODE_N_BIT]) begin
            view_flat[ADDR_KERN_P*DATA_W +: DATA_W] = DATA_W'(KERN_P_FORCED);
            view_flat[ADDR_KERN_M*DATA_W +: DATA_W] = DATA_W'(KERN_M_FORCED);
        end
    end
endmodule

// File: rtl/sercfg_loader.sv
// Module: sercfg_loader (top)
// Serial configuration loader: frames of address+data captured on rising
// edges, committed into eight registers on the following falling edge.
// Assumes one clock for serial and system use; both resets synchronous.
module sercfg_loader #(
    parameter int REG_COUNT = sercfg_pkg::REG_COUNT_DEF,
    parameter int DATA_W    = sercfg_pkg::DATA_W_DEF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         regs_rst_n,
    input  logic                         ser_load,
    input  logic                         ser_din,
    output logic [7:0]                   reg_calib_o,
    output logic [7:0]                   reg_edge_gain_o,
    output logic [7:0]                   reg_expo_hi_o,
    output logic [7:0]                   reg_expo_lo_o,
    output logic [7:0]                   reg_kern_p_o,
    output logic [7:0]                   reg_kern_m_o,
    output logic [7:0]                   reg_kern_x_o,
    output logic [7:0]                   reg_misc_o,
    output logic                         cfg_commit_o,
    output logic [$clog2(REG_COUNT)-1:0] cfg_commit_addr_o
);
    localparam int ADDR_W = $clog2(REG_COUNT);

    logic                        frm_vld;
    logic [ADDR_W-1:0]           frm_addr;
    logic [DATA_W-1:0]           frm_data;
    logic [REG_COUNT*DATA_W-1:0] bank_flat;
    logic [REG_COUNT*DATA_W-1:0] view_flat;

    sercfg_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_load (ser_load),
        .ser_din  (ser_din),
        .frm_vld  (frm_vld),
        .frm_addr (frm_addr),
        .frm_data (frm_data)
    );

    sercfg_bank #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W)) bank_i (
        .clk           (clk),
        .regs_rst_n    (regs_rst_n),
        .frm_vld       (frm_vld),
        .frm_addr      (frm_addr),
        .frm_data      (frm_data),
        .bank_flat     (bank_flat),
        .commit_o      (cfg_commit_o),
        .commit_addr_o (cfg_commit_addr_o)
    );

    sercfg_override #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W)) ovr_i (
        .bank_flat (bank_flat),
        .view_flat (view_flat)
    );

    // Map the packed view onto the named register outputs.
    always_comb begin
        reg_calib_o     = view_flat[0*DATA_W +: 8];
        reg_edge_gain_o = view_flat[1*DATA_W +: 8];
        reg_expo_hi_o   = view_flat[2*DATA_W +: 8];
        reg_expo_lo_o   = view_flat[3*DATA_W +: 8];
        reg_kern_p_o    = view_flat[4*DATA_W +: 8];
        reg_kern_m_o    = view_flat[5*DATA_W +: 8];
        reg_kern_x_o    = view_flat[6*DATA_W +: 8];
        reg_misc_o      = view_flat[7*DATA_W +: 8];
    end
endmodule

// File: rtl/sercfg_loader_chk.sv
// Module: sercfg_loader_chk
// Property checker bound to sercfg_loader: commit pulse shape and origin,
// register reset, bank stability and kernel override values.
module sercfg_loader_chk #(
    parameter int REG_COUNT = 8,
    parameter int DATA_W    = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        regs_rst_n,
    input logic                        frm_vld,
    input logic                        commit_o,
    input logic [REG_COUNT*DATA_W-1:0] bank_flat,
    input logic [7:0]                  p_o,
    input logic [7:0]                  m_o
);
    import sercfg_pkg::*;

    // R3: a commit pulse lasts one cycle and follows a flagged frame
    assert_commit_single_R3: assert property (@(negedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
    assert_commit_origin_R3: assert property (@(negedge clk) disable iff (!rst_n)
        commit_o |-> $past(frm_vld));

    // R6: register reset clears the whole bank
    assert_regs_clear_R6: assert property (@(negedge clk) disable iff (!rst_n)
        !regs_rst_n |=> (bank_flat == '0));

    // R2: without a commit the bank holds its contents
    assert_bank_stable_R2: assert property (@(negedge clk) disable iff (!rst_n)
        (!commit_o && $past(regs_rst_n)) |-> $stable(bank_flat));

    // R8: override bit forces the kernel outputs
    assert_override_vals_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bank_flat[ADDR_MODE*DATA_W + MODE_N_BIT] |-> (p_o == KERN_P_FORCED && m_o == KERN_M_FORCED));
endmodule

bind sercfg_loader sercfg_loader_chk #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .regs_rst_n (regs_rst_n),
    .frm_vld    (frm_vld),
    .commit_o   (cfg_commit_o),
    .bank_flat  (bank_flat),
    .p_o        (reg_kern_p_o),
    .m_o        (reg_kern_m_o)
);

// File: tb/sercfg_loader_tb_top.sv
// Directed bench for sercfg_loader: one task per scenario, each checking
// its own results against a reference model of the registers.
module sercfg_loader_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       regs_rst_n = 1'b0;
    logic       ser_load = 1'b0;
    logic       ser_din = 1'b0;
    logic [7:0] r_o [8];
    logic       commit;
    logic [2:0] commit_addr;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [8];
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sercfg_loader dut_i (
        .clk               (clk),
        .rst_n             (rst_n),
        .regs_rst_n        (regs_rst_n),
        .ser_load          (ser_load),
        .ser_din           (ser_din),
        .reg_calib_o       (r_o[0]),
        .reg_edge_gain_o   (r_o[1]),
        .reg_expo_hi_o     (r_o[2]),
        .reg_expo_lo_o     (r_o[3]),
        .reg_kern_p_o      (r_o[4]),
        .reg_kern_m_o      (r_o[5]),
        .reg_kern_x_o      (r_o[6]),
        .reg_misc_o        (r_o[7]),
        .cfg_commit_o      (commit),
        .cfg_commit_addr_o (commit_addr)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] eff(input int a);
        if (model[1][7] && a == 4) return 8'h02;
        if (model[1][7] && a == 5) return 8'h05;
        return model[a];
    endfunction

    task automatic check_all(input string tag);
        for (int a = 0; a < 8; a++) check(tag, r_o[a], eff(a));
    endtask

    // Advance to the drive point 15 ns after a rising edge.
    task automatic step();
        @(posedge clk);
        #15;
    endtask

    task automatic shift_bits(input logic [10:0] frame, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            ser_load = 1'b1;
            ser_din  = frame[10-i];
            step();
        end
    endtask

    task automatic end_load();
        ser_load = 1'b0;
        ser_din  = 1'b0;
        step();
    endtask

    // Full frame; returns with commit visible (if accepted), then drops load.
    task automatic send_frame(input logic [2:0] a, input logic [7:0] d,
                              input bit expect_ok, input string tag);
        shift_bits({a, d}, 11);
        check({tag, " commit"}, 8'(commit), 8'(expect_ok));
        if (expect_ok) begin
            model[a] = d;
            check({tag, " commit_addr"}, 8'(commit_addr), 8'(a));
        end
        check_all(tag);
        end_load();
        check({tag, " pulse end"}, 8'(commit), 8'h00);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; regs_rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1; regs_rst_n = 1'b1;
        step();
        for (int a = 0; a < 8; a++) model[a] = 8'h00;
        check_all("R6 reset state");
        check("R3 no commit at reset", 8'(commit), 8'h00);
    endtask

    task automatic test_write_all();
        for (int a = 0; a < 8; a++)
            send_frame(3'(a), 8'(8'h3C + a * 8'h13), 1'b1, "R1 write map");
    endtask

    task automatic test_commit_timing();
        shift_bits({3'd3, 8'hC6}, 10);
        ser_din = 1'b0;            // last bit of 0xC6
        @(posedge clk); #5;
        check("R2 old value before fall", r_o[3], model[3]);
        check("R3 no pulse before fall", 8'(commit), 8'h00);
        #10;
        model[3] = 8'hC6;
        check("R2 new value after fall", r_o[3], 8'hC6);
        check("R3 pulse after fall", 8'(commit), 8'h01);
        end_load();
    endtask

    task automatic test_partial();
        shift_bits({3'd2, 8'hE1}, 7);
        end_load();
        check("R4 partial no pulse", 8'(commit), 8'h00);
        check_all("R4 partial discarded");
        send_frame(3'd2, 8'h1E, 1'b1, "R4 after partial");
    endtask

    task automatic test_extra_bits();
        shift_bits({3'd6, 8'h5A}, 11);
        model[6] = 8'h5A;
        shift_bits(11'h7FF, 11);   // load stays high: all ignored
        check("R5 extra bits no pulse", 8'(commit), 8'h00);
        check_all("R5 extra bits ignored");
        end_load();
    endtask

    task automatic test_frame_reset();
        shift_bits({3'd0, 8'hFF}, 6);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        shift_bits({3'd0, 8'hFF}, 6);   // only 5 bits left of old frame
        check("R7 dropped frame no pulse", 8'(commit), 8'h00);
        check_all("R7 dropped frame");
        end_load();
        send_frame(3'd0, 8'h81, 1'b1, "R7 fresh frame");
    endtask

    task automatic test_override();
        send_frame(3'd4, 8'hA4, 1'b1, "R9 preset P");
        send_frame(3'd5, 8'hB5, 1'b1, "R9 preset M");
        send_frame(3'd1, 8'h95, 1'b1, "R8 set override");
        check("R8 P forced", r_o[4], 8'h02);
        check("R8 M forced", r_o[5], 8'h05);
        send_frame(3'd4, 8'h77, 1'b0, "R9 P write blocked");
        send_frame(3'd5, 8'h66, 1'b0, "R9 M write blocked");
        send_frame(3'd6, 8'h99, 1'b1, "R10 X write allowed");
        send_frame(3'd1, 8'h15, 1'b1, "R9 clear override");
        check("R9 P restored", r_o[4], 8'hA4);
        check("R9 M restored", r_o[5], 8'hB5);
    endtask

    task automatic test_regs_reset();
        regs_rst_n = 1'b0;
        shift_bits({3'd7, 8'h3F}, 11);   // write during register reset
        check("R6 blocked during reset", 8'(commit), 8'h00);
        end_load();
        regs_rst_n = 1'b1;
        step();
        for (int a = 0; a < 8; a++) model[a] = 8'h00;
        check_all("R6 cleared");
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_write_all();
        test_commit_timing();
        test_partial();
        test_extra_bits();
        test_frame_reset();
        test_override();
        test_regs_reset();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule